// File: doc/BRIEF.md
# PCIe Error Classification and Signaling

This block takes one detected error event at a time and decides what becomes of it. An event carries a 32-bit status vector, a correctable flag, an advisory flag and a 16-bit source ID. The block keeps only the bits that are supported for the event's class and drops the event unless exactly one bit remains. It then decides whether the error is correctable, non-fatal or fatal, and sets the sticky device status bits and the correctable and uncorrectable status registers. It weighs the mask, severity and reporting-enable settings and produces at most one error message.

Uncorrectable errors that must be recorded go to a separate header-log block as a one-cycle request. If that block reports that its storage has overflowed, the block first sends the original message. It then runs a header-log-overflow correctable event through the same decision path. A non-fatal error flagged as advisory is reported as a correctable advisory event and not as an uncorrectable one. All software-visible mask, severity and enable registers arrive as plain inputs. Clearing of the status registers comes in as write-one-to-clear vectors.

Top module: `pcie_err_signal`

## Requirements
- R1: The status vector is first ANDed with the supported set for its class. The correctable bits are 0, 6, 7, 8, 12, 13, 14 and 15. The uncorrectable bits are 4, 5 and 12 to 25. Unless exactly one bit remains, the event changes no register, sends no message and makes no log request.
- R2: A correctable event sets device status bit 0 and its own bit in the correctable status register. If that bit is set in the correctable mask, no message is sent.
- R3: An unmasked correctable event sends a message only when the correctable reporting enable is set. An unsupported-request event sent this way also needs the UR reporting enable. The severity code of a correctable message is 2'b01.
- R4: An uncorrectable event is fatal when its bit is set in the severity input. A fatal event sets device status bit 2 and a non-fatal one sets bit 1. An unsupported request (uncorrectable bit 20) also sets device status bit 3.
- R5: An uncorrectable event whose mask bit is set still sets its uncorrectable status bit. It makes no log request and sends no message.
- R6: A non-fatal event with the advisory flag is handled as a correctable event on correctable bit 13, and device status bit 0 is set. When bit 13 is not masked, its uncorrectable status bit is also set. A log request is then made only if its uncorrectable mask bit is clear, and the message follows R3.
- R7: A fatal message (code 2'b11) needs SERR enable or the fatal reporting enable. A non-fatal message (code 2'b10) needs SERR enable or the non-fatal reporting enable. An unsupported request is suppressed when both the UR reporting enable and SERR enable are clear.
- R8: When the log block answers a request with overflow, the original message comes out first. In the next cycle the block processes a correctable event on bit 15 with source ID 0.
- R9: When no severity register is present, the error is fatal for uncorrectable bits 4, 5, 13, 17, 18 and 22. All other supported bits are non-fatal.
- R10: An event is taken when valid and ready are both high. Its message is a one-cycle pulse in the next cycle, together with any log request. Ready is low in that log-request cycle, and an event offered then is ignored.
- R11: After reset all status registers are zero, no message or log request is pending, and ready is high.
- R12: The write-one-to-clear inputs clear status bits. A bit that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Event can be taken |
| ev_status | input | 32 | Error status vector |
| ev_is_cor | input | 1 | Event is correctable |
| ev_advisory | input | 1 | Event may be treated as advisory |
| ev_source | input | 16 | Requester source ID |
| cfg_cor_mask | input | 32 | Correctable mask |
| cfg_unc_mask | input | 32 | Uncorrectable mask |
| cfg_unc_sev | input | 32 | Uncorrectable severity (1 = fatal) |
| cfg_sev_present | input | 1 | Severity register implemented |
| cfg_serr_en | input | 1 | SERR enable |
| cfg_cor_rep_en | input | 1 | Correctable reporting enable |
| cfg_nf_rep_en | input | 1 | Non-fatal reporting enable |
| cfg_fat_rep_en | input | 1 | Fatal reporting enable |
| cfg_ur_rep_en | input | 1 | Unsupported-request reporting enable |
| clr_cor | input | 32 | Write-one-to-clear for correctable status |
| clr_unc | input | 32 | Write-one-to-clear for uncorrectable status |
| clr_dev | input | 4 | Write-one-to-clear for device status |
| cor_sts | output | 32 | Correctable status |
| unc_sts | output | 32 | Uncorrectable status |
| dev_sts | output | 4 | Device status: 0 cor, 1 non-fatal, 2 fatal, 3 UR |
| log_req | output | 1 | Log request pulse |
| log_status | output | 32 | One-hot uncorrectable bit to record |
| log_source | output | 16 | Source ID to record |
| log_ovf | input | 1 | Log overflow, valid with log_req |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_source | output | 16 | Message source ID |

## Verification
Some rules hold on every cycle, and the assertions check those. Status bits never drop unless a clear asks for it. A log request is always one-hot and always holds ready low. A correctable or fatal message always comes with the matching device status bit. An overflow answer always leaves the overflow status bit set in the next cycle.

Other behaviour depends on which event meets which settings, and only the bench scenarios can show it. This covers the choice among the mask, the severity input and the default severity, the suppression of unsupported requests, and the advisory rerouting. It also covers the order of the original message and its overflow follow-up. The bench compares these against its reference model on every clock.

// File: rtl/pcie_err_pkg.sv
package pcie_err_pkg;
  localparam int STS_W = 32;
  localparam int DEV_W = 4;

  typedef logic [1:0] sev_t;
  localparam sev_t SEV_NONE     = 2'b00;
  localparam sev_t SEV_COR      = 2'b01;
  localparam sev_t SEV_NONFATAL = 2'b10;
  localparam sev_t SEV_FATAL    = 2'b11;

  localparam int COR_ADV_BIT   = 13;
  localparam int COR_HLOVF_BIT = 15;
  localparam int UNC_UR_BIT    = 20;

  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;

  localparam logic [STS_W-1:0] COR_SUP_DEF   = 32'h0000_F1C1;
  localparam logic [STS_W-1:0] UNC_SUP_DEF   = 32'h03FF_F030;
  localparam logic [STS_W-1:0] UNC_FATAL_DEF = 32'h0046_2030;
endpackage

// File: rtl/pcie_err_classify.sv
module pcie_err_classify
  import pcie_err_pkg::*;
#(
  parameter logic [STS_W-1:0] COR_SUP   = COR_SUP_DEF,
  parameter logic [STS_W-1:0] UNC_SUP   = UNC_SUP_DEF,
  parameter logic [STS_W-1:0] UNC_FATAL = UNC_FATAL_DEF
) (
  input  logic             go,
  input  logic [STS_W-1:0] status,
  input  logic             is_cor,
  input  logic             advisory,
  input  logic [STS_W-1:0] cor_mask,
  input  logic [STS_W-1:0] unc_mask,
  input  logic [STS_W-1:0] unc_sev,
  input  logic             sev_present,
  input  logic             serr_en,
  input  logic             cor_en,
  input  logic             nf_en,
  input  logic             fat_en,
  input  logic             ur_en,
  output logic [STS_W-1:0] cor_set,
  output logic [STS_W-1:0] unc_set,
  output logic [DEV_W-1:0] dev_set,
  output logic             log_go,
  output logic [STS_W-1:0] log_bit,
  output logic             send,
  output sev_t             sev
);
  localparam logic [STS_W-1:0] ADV_ONEHOT = STS_W'(1) << COR_ADV_BIT;

  logic [STS_W-1:0] sup;
  logic             one_bit, is_ur, fatal, adv_path, cor_path;
  logic [STS_W-1:0] cor_bit;
  logic             cor_masked, unc_masked;

  always_comb begin
    sup        = is_cor ? (status & COR_SUP) : (status & UNC_SUP);
    one_bit    = (sup != '0) && ((sup & (sup - STS_W'(1))) == '0);
    is_ur      = !is_cor && sup[UNC_UR_BIT];
    fatal      = !is_cor && (sev_present ? |(sup & unc_sev) : |(sup & UNC_FATAL));
    adv_path   = !is_cor && !fatal && advisory;
    cor_path   = is_cor || adv_path;
    cor_bit    = is_cor ? sup : ADV_ONEHOT;
    cor_masked = |(cor_bit & cor_mask);
    unc_masked = |(sup & unc_mask);

    cor_set = '0;
    unc_set = '0;
    dev_set = '0;
    log_go  = 1'b0;
    send    = 1'b0;
    sev     = SEV_NONE;
    log_bit = sup;

    if (go && one_bit) begin
      dev_set[DEV_UR] = is_ur;
      if (cor_path) begin
        dev_set[DEV_COR] = 1'b1;
        cor_set          = cor_bit;
        if (!cor_masked && adv_path) begin
          unc_set = sup;
          log_go  = !unc_masked;
        end
        send = !cor_masked && !(is_ur && !ur_en) && cor_en;
        sev  = SEV_COR;
      end else begin
        dev_set[DEV_FAT] = fatal;
        dev_set[DEV_NF]  = !fatal;
        unc_set          = sup;
        log_go           = !unc_masked;
        send = !unc_masked && !(is_ur && !ur_en && !serr_en) &&
               (serr_en || (fatal ? fat_en : nf_en));
        sev  = fatal ? SEV_FATAL : SEV_NONFATAL;
      end
    end
  end
endmodule

// File: rtl/pcie_err_sticky.sv
module pcie_err_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr) | set;
  end
endmodule

// File: rtl/pcie_err_signal.sv
module pcie_err_signal
  import pcie_err_pkg::*;
#(
  parameter int               SRC_W     = 16,
  parameter logic [STS_W-1:0] COR_SUP   = COR_SUP_DEF,
  parameter logic [STS_W-1:0] UNC_SUP   = UNC_SUP_DEF,
  parameter logic [STS_W-1:0] UNC_FATAL = UNC_FATAL_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  output logic             ev_ready,
  input  logic [STS_W-1:0] ev_status,
  input  logic             ev_is_cor,
  input  logic             ev_advisory,
  input  logic [SRC_W-1:0] ev_source,
  input  logic [STS_W-1:0] cfg_cor_mask,
  input  logic [STS_W-1:0] cfg_unc_mask,
  input  logic [STS_W-1:0] cfg_unc_sev,
  input  logic             cfg_sev_present,
  input  logic             cfg_serr_en,
  input  logic             cfg_cor_rep_en,
  input  logic             cfg_nf_rep_en,
  input  logic             cfg_fat_rep_en,
  input  logic             cfg_ur_rep_en,
  input  logic [STS_W-1:0] clr_cor,
  input  logic [STS_W-1:0] clr_unc,
  input  logic [DEV_W-1:0] clr_dev,
  output logic [STS_W-1:0] cor_sts,
  output logic [STS_W-1:0] unc_sts,
  output logic [DEV_W-1:0] dev_sts,
  output logic             log_req,
  output logic [STS_W-1:0] log_status,
  output logic [SRC_W-1:0] log_source,
  input  logic             log_ovf,
  output logic             msg_valid,
  output sev_t             msg_sev,
  output logic [SRC_W-1:0] msg_source
);
  localparam logic [STS_W-1:0] HLOVF_ONEHOT = STS_W'(1) << COR_HLOVF_BIT;

  logic             follow_up, take, go;
  logic [STS_W-1:0] c_status;
  logic             c_is_cor, c_adv;
  logic [SRC_W-1:0] c_src;
  logic [STS_W-1:0] cor_set, unc_set, log_bit;
  logic [DEV_W-1:0] dev_set;
  logic             log_go, send;
  sev_t             sev;

  assign ev_ready  = !log_req;
  assign take      = ev_valid && ev_ready;
  assign follow_up = log_req && log_ovf;
  assign go        = take || follow_up;

  always_comb begin
    if (follow_up) begin
      c_status = HLOVF_ONEHOT;
      c_is_cor = 1'b1;
      c_adv    = 1'b0;
      c_src    = '0;
    end else begin
      c_status = ev_status;
      c_is_cor = ev_is_cor;
      c_adv    = ev_advisory;
      c_src    = ev_source;
    end
  end

  pcie_err_classify #(
    .COR_SUP(COR_SUP), .UNC_SUP(UNC_SUP), .UNC_FATAL(UNC_FATAL)
  ) u_class (
    .go(go), .status(c_status), .is_cor(c_is_cor), .advisory(c_adv),
    .cor_mask(cfg_cor_mask), .unc_mask(cfg_unc_mask), .unc_sev(cfg_unc_sev),
    .sev_present(cfg_sev_present), .serr_en(cfg_serr_en),
    .cor_en(cfg_cor_rep_en), .nf_en(cfg_nf_rep_en), .fat_en(cfg_fat_rep_en),
    .ur_en(cfg_ur_rep_en),
    .cor_set(cor_set), .unc_set(unc_set), .dev_set(dev_set),
    .log_go(log_go), .log_bit(log_bit), .send(send), .sev(sev)
  );

  pcie_err_sticky #(.W(STS_W)) u_cor (
    .clk(clk), .rst(rst), .set(cor_set), .clr(clr_cor), .q(cor_sts));
  pcie_err_sticky #(.W(STS_W)) u_unc (
    .clk(clk), .rst(rst), .set(unc_set), .clr(clr_unc), .q(unc_sts));
  pcie_err_sticky #(.W(DEV_W)) u_dev (
    .clk(clk), .rst(rst), .set(dev_set), .clr(clr_dev), .q(dev_sts));

  always_ff @(posedge clk) begin
    if (rst) begin
      log_req    <= 1'b0;
      log_status <= '0;
      log_source <= '0;
      msg_valid  <= 1'b0;
      msg_sev    <= SEV_NONE;
      msg_source <= '0;
    end else begin
      log_req   <= log_go;
      msg_valid <= send;
      if (log_go) begin
        log_status <= log_bit;
        log_source <= c_src;
      end
      if (send) begin
        msg_sev    <= sev;
        msg_source <= c_src;
      end
    end
  end
endmodule

// File: rtl/pcie_err_signal_chk.sv
module pcie_err_signal_chk
  import pcie_err_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ev_ready,
  input logic [STS_W-1:0] clr_cor,
  input logic [STS_W-1:0] clr_unc,
  input logic [STS_W-1:0] cor_sts,
  input logic [STS_W-1:0] unc_sts,
  input logic [DEV_W-1:0] dev_sts,
  input logic             log_req,
  input logic [STS_W-1:0] log_status,
  input logic             log_ovf,
  input logic             msg_valid,
  input logic [1:0]       msg_sev
);
  AST_LOG_ONE_BIT: assert property (@(posedge clk) disable iff (rst) log_req |-> $countones(log_status) == 1); // R1
  AST_COR_DEV_BIT: assert property (@(posedge clk) disable iff (rst) (msg_valid && msg_sev == SEV_COR) |-> dev_sts[DEV_COR]); // R2
  AST_SEV_CODE: assert property (@(posedge clk) disable iff (rst) msg_valid |-> msg_sev != SEV_NONE); // R3
  AST_FATAL_DEV_BIT: assert property (@(posedge clk) disable iff (rst) (msg_valid && msg_sev == SEV_FATAL) |-> dev_sts[DEV_FAT]); // R4
  AST_OVF_FOLLOW: assert property (@(posedge clk) disable iff (rst) (log_req && log_ovf) |=> cor_sts[COR_HLOVF_BIT]); // R8
  AST_BLOCK_READY: assert property (@(posedge clk) disable iff (rst) log_req |-> !ev_ready); // R10
  AST_COR_STICKY: assert property (@(posedge clk) disable iff (rst) (($past(cor_sts) & ~cor_sts & ~$past(clr_cor)) == '0)); // R12
  AST_UNC_STICKY: assert property (@(posedge clk) disable iff (rst) (($past(unc_sts) & ~unc_sts & ~$past(clr_unc)) == '0)); // R12
endmodule

bind pcie_err_signal pcie_err_signal_chk u_chk (
  .clk(clk), .rst(rst), .ev_ready(ev_ready), .clr_cor(clr_cor), .clr_unc(clr_unc),
  .cor_sts(cor_sts), .unc_sts(unc_sts), .dev_sts(dev_sts), .log_req(log_req),
  .log_status(log_status), .log_ovf(log_ovf), .msg_valid(msg_valid), .msg_sev(msg_sev)
);

// File: tb/tb_pcie_err_signal.sv
module tb_pcie_err_signal;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic        ev_valid = 0, ev_is_cor = 0, ev_advisory = 0;
  logic [31:0] ev_status = 0;
  logic [15:0] ev_source = 0;
  logic [31:0] cfg_cor_mask = 0, cfg_unc_mask = 0, cfg_unc_sev = 0;
  logic        cfg_sev_present = 1, cfg_serr_en = 0, cfg_cor_rep_en = 0;
  logic        cfg_nf_rep_en = 0, cfg_fat_rep_en = 0, cfg_ur_rep_en = 0;
  logic [31:0] clr_cor = 0, clr_unc = 0;
  logic [3:0]  clr_dev = 0;
  logic        ovf_force = 0;
  logic        ev_ready, log_req, log_ovf, msg_valid;
  logic [31:0] cor_sts, unc_sts, log_status;
  logic [3:0]  dev_sts;
  logic [15:0] log_source, msg_source;
  logic [1:0]  msg_sev;

  assign log_ovf = log_req & ovf_force;

  pcie_err_signal dut (.*);

  int    n_checks = 0, n_fail = 0;
  string cur_req = "R11";
  bit    done = 0;

  // reference model state
  logic [31:0] m_cor, m_unc, m_logst;
  logic [3:0]  m_dev;
  logic        m_logreq, m_msgv;
  logic [1:0]  m_sev;
  logic [15:0] m_msgsrc, m_logsrc;

  function automatic int popcount(input logic [31:0] v);
    int n = 0;
    for (int i = 0; i < 32; i++) if (v[i]) n++;
    return n;
  endfunction

  task automatic model_event(input logic [31:0] st, input bit corr, input bit adv,
                             input logic [15:0] src);
    logic [31:0] s;
    bit ur, fat, msk, sendit;
    int pos;
    s = corr ? (st & 32'h0000_F1C1) : (st & 32'h03FF_F030);
    if (popcount(s) != 1) return;
    pos = 0;
    for (int i = 0; i < 32; i++) if (s[i]) pos = i;
    ur  = !corr && pos == 20;
    fat = 0;
    if (!corr) begin
      if (cfg_sev_present) fat = cfg_unc_sev[pos];
      else fat = (pos == 4 || pos == 5 || pos == 13 || pos == 17 || pos == 18 || pos == 22);
    end
    if (ur) m_dev[3] = 1;
    if (corr || (!fat && adv)) begin
      int cb = corr ? pos : 13;
      m_dev[0] = 1;
      m_cor[cb] = 1;
      if (cfg_cor_mask[cb]) return;
      if (!corr) begin
        if (!cfg_unc_mask[pos]) begin
          m_logreq = 1; m_logst = s; m_logsrc = src;
        end
        m_unc[pos] = 1;
      end
      if (ur && !cfg_ur_rep_en) return;
      if (!cfg_cor_rep_en) return;
      m_msgv = 1; m_sev = 2'b01; m_msgsrc = src;
    end else begin
      if (fat) m_dev[2] = 1; else m_dev[1] = 1;
      m_unc[pos] = 1;
      if (cfg_unc_mask[pos]) return;
      m_logreq = 1; m_logst = s; m_logsrc = src;
      if (ur && !cfg_ur_rep_en && !cfg_serr_en) return;
      sendit = cfg_serr_en || (fat ? cfg_fat_rep_en : cfg_nf_rep_en);
      if (!sendit) return;
      m_msgv = 1; m_sev = fat ? 2'b11 : 2'b10; m_msgsrc = src;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cor = 0; m_unc = 0; m_dev = 0; m_logreq = 0; m_msgv = 0;
      m_logst = 0; m_logsrc = 0; m_sev = 0; m_msgsrc = 0;
    end else begin
      bit acc, fu;
      acc = ev_valid && !m_logreq;
      fu  = m_logreq && ovf_force;
      m_cor = m_cor & ~clr_cor;
      m_unc = m_unc & ~clr_unc;
      m_dev = m_dev & ~clr_dev;
      m_logreq = 0; m_msgv = 0;
      if (fu) model_event(32'h0000_8000, 1, 0, 16'h0000);
      else if (acc) model_event(ev_status, ev_is_cor, ev_advisory, ev_source);
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done && $time > 6) begin
      chk("ready", {31'b0, ev_ready}, {31'b0, !m_logreq});
      chk("cor_sts", cor_sts, m_cor);
      chk("unc_sts", unc_sts, m_unc);
      chk("dev_sts", {28'b0, dev_sts}, {28'b0, m_dev});
      chk("msg_valid", {31'b0, msg_valid}, {31'b0, m_msgv});
      if (m_msgv) chk("msg", {14'b0, msg_sev, msg_source}, {14'b0, m_sev, m_msgsrc});
      chk("log_req", {31'b0, log_req}, {31'b0, m_logreq});
      if (m_logreq) chk("log", log_status ^ {16'b0, log_source}, m_logst ^ {16'b0, m_logsrc});
    end
  end

  task automatic send(input logic [31:0] st, input bit c, input bit a, input logic [15:0] s);
    @(negedge clk);
    ev_valid = 1; ev_status = st; ev_is_cor = c; ev_advisory = a; ev_source = s;
    @(negedge clk);
    ev_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R1: rejection of non one-hot or unsupported vectors
    cur_req = "R1";
    send(32'h0000_0030, 0, 0, 16'h1111);
    send(32'h0000_0001, 0, 0, 16'h1112);
    send(32'h0000_0000, 1, 0, 16'h1113);
    send(32'h0000_0002, 1, 0, 16'h1114);
    // R2 / R3: correctable paths
    cur_req = "R2";
    send(32'h0000_0040, 1, 0, 16'h2001);
    cur_req = "R3";
    cfg_cor_rep_en = 1;
    send(32'h0000_0080, 1, 0, 16'h2002);
    cur_req = "R2";
    cfg_cor_mask = 32'h0000_0100;
    send(32'h0000_0100, 1, 0, 16'h2003);
    cfg_cor_mask = 0;
    // R4 / R7: severity register decides
    cur_req = "R4";
    cfg_sev_present = 1; cfg_unc_sev = 32'h0000_1000; cfg_fat_rep_en = 1;
    send(32'h0000_1000, 0, 0, 16'h4001);
    cur_req = "R7";
    send(32'h0000_4000, 0, 0, 16'h4002);
    cfg_serr_en = 1;
    send(32'h0000_4000, 0, 0, 16'h4003);
    cfg_serr_en = 0; cfg_fat_rep_en = 0;
    send(32'h0000_1000, 0, 0, 16'h4004);
    cfg_nf_rep_en = 1;
    send(32'h0000_8000, 0, 0, 16'h4005);
    // R9: default severity
    cur_req = "R9";
    cfg_sev_present = 0; cfg_fat_rep_en = 1;
    send(32'h0004_0000, 0, 0, 16'h9001);
    send(32'h0000_0020, 0, 0, 16'h9002);
    send(32'h0001_0000, 0, 0, 16'h9003);
    cfg_sev_present = 1;
    // R5: masked uncorrectable
    cur_req = "R5";
    cfg_unc_mask = 32'h0000_2000;
    send(32'h0000_2000, 0, 0, 16'h5001);
    cfg_unc_mask = 0;
    // R4 / R7: unsupported request
    cur_req = "R7";
    clr_dev = 4'hF; @(negedge clk); clr_dev = 0;
    send(32'h0010_0000, 0, 0, 16'h7001);
    cfg_ur_rep_en = 1;
    send(32'h0010_0000, 0, 0, 16'h7002);
    cfg_ur_rep_en = 0; cfg_serr_en = 1;
    send(32'h0010_0000, 0, 0, 16'h7003);
    cfg_serr_en = 0;
    // R6: advisory non-fatal
    cur_req = "R6";
    clr_unc = 32'hFFFF_FFFF; clr_cor = 32'hFFFF_FFFF; @(negedge clk);
    clr_unc = 0; clr_cor = 0;
    send(32'h0000_4000, 0, 1, 16'h6001);
    cfg_unc_mask = 32'h0000_8000;
    send(32'h0000_8000, 0, 1, 16'h6002);
    cfg_unc_mask = 0; cfg_cor_mask = 32'h0000_2000;
    send(32'h0001_0000, 0, 1, 16'h6003);
    cfg_cor_mask = 0;
    send(32'h0010_0000, 0, 1, 16'h6004);
    cfg_ur_rep_en = 1;
    send(32'h0010_0000, 0, 1, 16'h6005);
    send(32'h0004_0000, 0, 1, 16'h6006);
    // R8 / R10: overflow follow-up and blocked offer
    cur_req = "R8";
    ovf_force = 1;
    send(32'h0000_4000, 0, 0, 16'h8001);
    cur_req = "R10";
    @(negedge clk);
    ev_valid = 1; ev_status = 32'h0000_0001; ev_is_cor = 1; ev_advisory = 0; ev_source = 16'hA001;
    @(negedge clk);
    ev_status = 32'h0000_8000; ev_is_cor = 0; ev_source = 16'hA002;
    @(negedge clk);
    ev_status = 32'h0000_0040; ev_is_cor = 1; ev_source = 16'hA003;
    @(negedge clk);
    ev_valid = 0; ovf_force = 0;
    repeat (3) @(negedge clk);
    // R12: clear and set-wins
    cur_req = "R12";
    clr_cor = 32'h0000_0040; clr_unc = 32'h0000_4000; clr_dev = 4'h1;
    @(negedge clk);
    clr_cor = 0; clr_unc = 0; clr_dev = 0;
    @(negedge clk);
    ev_valid = 1; ev_status = 32'h0000_1000; ev_is_cor = 1; ev_source = 16'hC001;
    clr_cor = 32'h0000_1000; clr_dev = 4'h1;
    @(negedge clk);
    ev_valid = 0; clr_cor = 0; clr_dev = 0;
    repeat (3) @(negedge clk);
    // R11: reset returns everything to idle
    cur_req = "R11";
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule